// File: doc/BRIEF.md
# Interrupt Pin Trigger and End-of-Interrupt Tracker

This block sits between a bank of interrupt input lines and the dispatcher that resolves destinations. Each cycle it looks at a rising-edge event and the present level of every pin, and at the routing configuration of every pin: mask, trigger mode and vector. From these it decides which pins need a delivery. Pins configured for level triggering carry an in-service flag (remote IRR). The flag is set when a delivery is launched. It is cleared when an end-of-interrupt message names the pin's vector.

Requests wait in a per-pin pending register. One request at a time is handed to the dispatcher through a valid/ready handshake that carries the pin index. When an end-of-interrupt message arrives, it is matched to a pin by searching the vector fields from pin 0 upward. The first match wins. If that pin is level triggered, unmasked and its line is still high, a fresh delivery is launched at once.

Top module: `irq_pin_tracker`

## Requirements
- R1: After reset, no delivery is offered (`dlv_valid` low) and every remote-IRR bit is 0.
- R2: A rising edge on a pin whose `cfg_mask` bit is 1 produces no delivery and leaves its remote-IRR bit unchanged.
- R3: A pin with `cfg_level` = 0 (edge mode) and mask 0 produces one delivery for each rising edge that is accepted while no request for it is pending. Its remote-IRR bit stays 0.
- R4: A pin with `cfg_level` = 1 (level mode) and mask 0 produces a delivery on a rising edge only when its remote-IRR bit is 0, and that edge sets the bit to 1. An edge that arrives while the bit is 1 is dropped.
- R5: An end-of-interrupt message (`eoi_valid` = 1) is matched against the vector fields of pins 0 to N-1 in ascending order. Only the lowest-indexed pin with an equal vector has its remote-IRR bit cleared.
- R6: An end-of-interrupt message whose vector matches no pin changes no remote-IRR bit and produces no delivery.
- R7: If the matched pin is level mode, unmasked and its `line_lvl` bit is 1, its remote-IRR bit is set again and a new delivery is issued for it.
- R8: When several pins have pending requests, the lowest pin index is offered first. One delivery is made per cycle in which `dlv_ready` is 1. While `dlv_ready` is 0, `dlv_valid` stays high and the requests stay pending.
- R9: Further accepted edges on a pin whose request is still pending merge into that request, so only one delivery results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edge_evt | input | NPINS | One-cycle rising-edge event per pin |
| line_lvl | input | NPINS | Present level of each input line |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_vector | input | NPINS*VEC_W | Per-pin vector, pin i at bits [i*VEC_W +: VEC_W] |
| eoi_valid | input | 1 | End-of-interrupt message strobe |
| eoi_vector | input | VEC_W | Vector carried by the end-of-interrupt message |
| dlv_ready | input | 1 | Dispatcher accepts the offered delivery |
| dlv_valid | output | 1 | A delivery request is offered |
| dlv_pin | output | IDX_W | Pin index of the offered delivery |
| remote_irr | output | NPINS | Per-pin remote-IRR state |

## Verification
The bench builds the tracker with NPINS = 6 and VEC_W = 8. A pin count that is not a power of two leaves unused index codes, so the lowest-index encoder and its width derivation are exercised on a non-trivial width. Six pins are enough for two level pins to share a vector, which tests the ascending search. They also allow three edge pins to contend at once while the dispatcher stalls. The 8-bit vectors give room for an end-of-interrupt value that matches nothing.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_mode_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/irq_trig_cell.sv
module irq_trig_cell
   import irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   input  logic line_i,
   input  logic mask_i,
   input  logic level_i,
   input  logic eoi_hit_i,
   input  logic take_i,
   output logic pend_o,
   output logic rirr_o
);
   logic pend_q, rirr_q;
   logic is_level, accept_edge, redeliver;

   assign is_level    = (trig_mode_e'(level_i) == TRIG_LEVEL);
   assign accept_edge = edge_i & ~mask_i & (~is_level | ~rirr_q);
   assign redeliver   = eoi_hit_i & is_level & ~mask_i & line_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         rirr_q <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~take_i) | accept_edge | redeliver;
         rirr_q <= (rirr_q & ~eoi_hit_i) | redeliver | (accept_edge & is_level);
      end
   end

   assign pend_o = pend_q;
   assign rirr_o = rirr_q;

   assert_masked_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && mask_i && !eoi_hit_i && !pend_q) |=> !pend_q);

   assert_edge_no_rirr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_i && !rirr_q) |=> !rirr_q);

   assert_level_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && level_i && rirr_q && !eoi_hit_i && !pend_q) |=> !pend_q);

   assert_level_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_i && level_i && !mask_i) |=> rirr_q);

   assert_redeliver_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit_i && level_i && !mask_i && line_i) |=> (rirr_q && pend_q));
endmodule

// File: rtl/irq_eoi_match.sv
module irq_eoi_match #(
   parameter int unsigned NPINS = 8,
   parameter int unsigned VEC_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPINS*VEC_W-1:0] vectors_i,
   input  logic                   eoi_valid_i,
   input  logic [VEC_W-1:0]       eoi_vector_i,
   output logic [NPINS-1:0]       hit_o
);
   logic [NPINS-1:0] eq;

   for (genvar g = 0; g < NPINS; g++) begin : g_cmp
      assign eq[g] = (vectors_i[g*VEC_W +: VEC_W] == eoi_vector_i);
   end

   always_comb begin
      logic found;
      found = 1'b0;
      hit_o = '0;
      for (int i = 0; i < NPINS; i++) begin
         if (eoi_valid_i && eq[i] && !found) begin
            hit_o[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   assert_single_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_o));

   assert_hit_needs_eoi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !eoi_valid_i |-> (hit_o == '0));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
   parameter int unsigned NPINS = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] req_i,
   output logic [NPINS-1:0] grant_o,
   output logic [IDX_W-1:0] idx_o
);
   assign grant_o = req_i & ~(req_i - 1'b1);

   always_comb begin
      idx_o = '0;
      for (int i = NPINS - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end

   assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o) && ((|req_i) == (|grant_o)));
endmodule

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker
   import irq_pkg::*;
#(
   parameter int unsigned NPINS = 8,
   parameter int unsigned VEC_W = 8,
   localparam int unsigned IDX_W = idx_width(NPINS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPINS-1:0]       edge_evt,
   input  logic [NPINS-1:0]       line_lvl,
   input  logic [NPINS-1:0]       cfg_mask,
   input  logic [NPINS-1:0]       cfg_level,
   input  logic [NPINS*VEC_W-1:0] cfg_vector,
   input  logic                   eoi_valid,
   input  logic [VEC_W-1:0]       eoi_vector,
   input  logic                   dlv_ready,
   output logic                   dlv_valid,
   output logic [IDX_W-1:0]       dlv_pin,
   output logic [NPINS-1:0]       remote_irr
);
   if (NPINS < 2 || NPINS > 256) begin : g_bad_npins
      $error("irq_pin_tracker: NPINS out of range");
   end
   if (VEC_W < 1 || VEC_W > 32) begin : g_bad_vecw
      $error("irq_pin_tracker: VEC_W out of range");
   end

   logic [NPINS-1:0] pend, grant, hit, take;

   irq_eoi_match #(.NPINS(NPINS), .VEC_W(VEC_W)) u_match (
      .clk(clk), .rst_n(rst_n), .vectors_i(cfg_vector),
      .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vector), .hit_o(hit)
   );

   irq_prio_arb #(.NPINS(NPINS), .IDX_W(IDX_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_i(pend), .grant_o(grant), .idx_o(dlv_pin)
   );

   assign take = grant & {NPINS{dlv_ready}};

   for (genvar g = 0; g < NPINS; g++) begin : g_pin
      irq_trig_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .edge_i(edge_evt[g]), .line_i(line_lvl[g]),
         .mask_i(cfg_mask[g]), .level_i(cfg_level[g]),
         .eoi_hit_i(hit[g]), .take_i(take[g]),
         .pend_o(pend[g]), .rirr_o(remote_irr[g])
      );
   end

   assign dlv_valid = |pend;

   assert_hold_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid && !dlv_ready) |=> dlv_valid);

   assert_nomatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && hit == '0 && edge_evt == '0) |=> (remote_irr == $past(remote_irr)));

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!dlv_valid && remote_irr == '0));
endmodule

// File: tb/irq_pin_tracker_test.sv
module irq_pin_tracker_test;
   localparam int NP = 6;
   localparam int VW = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0] edge_evt = '0, line_lvl = '0, cfg_mask = '1, cfg_level = '0;
   logic [NP*VW-1:0] cfg_vector = '0;
   logic eoi_valid = 1'b0;
   logic [VW-1:0] eoi_vector = '0;
   logic dlv_ready = 1'b1;
   logic dlv_valid;
   logic [IW-1:0] dlv_pin;
   logic [NP-1:0] remote_irr;

   int checks = 0;
   int errors = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_pin_tracker #(.NPINS(NP), .VEC_W(VW)) uut (
      .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt), .line_lvl(line_lvl),
      .cfg_mask(cfg_mask), .cfg_level(cfg_level), .cfg_vector(cfg_vector),
      .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .dlv_ready(dlv_ready),
      .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .remote_irr(remote_irr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: every handshake must match the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && dlv_valid && dlv_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected delivery", int'(dlv_pin), -1);
         end else begin
            int e;
            e = exp_q.pop_front();
            chk(int'(dlv_pin) == e, "R8 delivery order", int'(dlv_pin), e);
         end
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic pulse_edges(input logic [NP-1:0] m);
      edge_evt = m;
      tick(1);
      edge_evt = '0;
   endtask

   task automatic send_eoi(input logic [VW-1:0] v);
      eoi_valid = 1'b1;
      eoi_vector = v;
      tick(1);
      eoi_valid = 1'b0;
   endtask

   task automatic at_negedge();
      @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < NP; i++) cfg_vector[i*VW +: VW] = VW'(8'h10 + i);
      tick(3);
      at_negedge();
      chk(dlv_valid == 1'b0, "R1 valid after reset", dlv_valid, 0);
      chk(remote_irr == '0, "R1 remote_irr after reset", remote_irr, 0);
      rst_n = 1'b1;
      tick(1);

      // R2: masked pins ignore edges
      pulse_edges(6'b000100);
      tick(3);
      at_negedge();
      chk(dlv_valid == 1'b0, "R2 masked edge", dlv_valid, 0);
      chk(remote_irr == '0, "R2 masked rirr", remote_irr, 0);

      // configure: pins 3,4 level, rest edge; unmask all
      tick(1);
      cfg_mask = '0;
      cfg_level = 6'b011000;

      // R3: edge mode delivers on every edge
      exp_q.push_back(1);
      pulse_edges(6'b000010);
      tick(3);
      exp_q.push_back(1);
      pulse_edges(6'b000010);
      tick(3);
      at_negedge();
      chk(exp_q.size() == 0, "R3 two edge deliveries", exp_q.size(), 0);
      chk(remote_irr[1] == 1'b0, "R3 rirr stays clear", remote_irr[1], 0);

      // R4: level mode sets rirr and gates further edges
      tick(1);
      line_lvl = 6'b011000;
      exp_q.push_back(3);
      pulse_edges(6'b001000);
      tick(3);
      at_negedge();
      chk(remote_irr[3] == 1'b1, "R4 rirr set", remote_irr[3], 1);
      tick(1);
      pulse_edges(6'b001000);
      at_negedge();
      chk(dlv_valid == 1'b0, "R4 gated edge", dlv_valid, 0);

      // R6: unmatched EOI has no effect
      tick(1);
      send_eoi(8'hEE);
      tick(2);
      at_negedge();
      chk(remote_irr == 6'b001000, "R6 unmatched eoi", remote_irr, 6'b001000);
      chk(dlv_valid == 1'b0, "R6 no delivery", dlv_valid, 0);

      // R5: shared vector, lowest pin cleared only
      tick(1);
      cfg_vector[3*VW +: VW] = 8'h33;
      cfg_vector[4*VW +: VW] = 8'h33;
      exp_q.push_back(4);
      pulse_edges(6'b010000);
      tick(3);
      at_negedge();
      chk(remote_irr == 6'b011000, "R5 both rirr set", remote_irr, 6'b011000);
      tick(1);
      line_lvl = 6'b010000;
      send_eoi(8'h33);
      tick(2);
      at_negedge();
      chk(remote_irr == 6'b010000, "R5 lowest match cleared", remote_irr, 6'b010000);
      chk(exp_q.size() == 0 && dlv_valid == 1'b0, "R5 no redelivery low line", dlv_valid, 0);

      // R7: matched level pin with line high redelivers
      tick(1);
      cfg_vector[3*VW +: VW] = 8'h40;
      exp_q.push_back(4);
      send_eoi(8'h33);
      tick(3);
      at_negedge();
      chk(exp_q.size() == 0, "R7 redelivery issued", exp_q.size(), 0);
      chk(remote_irr[4] == 1'b1, "R7 rirr set again", remote_irr[4], 1);

      // R8: lowest index first, hold while stalled
      tick(1);
      dlv_ready = 1'b0;
      pulse_edges(6'b100101);
      tick(3);
      at_negedge();
      chk(dlv_valid == 1'b1, "R8 valid held", dlv_valid, 1);
      chk(int'(dlv_pin) == 0, "R8 lowest offered", int'(dlv_pin), 0);
      tick(1);
      exp_q.push_back(0);
      exp_q.push_back(2);
      exp_q.push_back(5);
      dlv_ready = 1'b1;
      tick(6);
      at_negedge();
      chk(exp_q.size() == 0, "R8 all delivered", exp_q.size(), 0);

      // R9: repeated edges while pending merge
      tick(1);
      dlv_ready = 1'b0;
      pulse_edges(6'b000010);
      tick(1);
      pulse_edges(6'b000010);
      tick(1);
      exp_q.push_back(1);
      dlv_ready = 1'b1;
      tick(5);
      at_negedge();
      chk(exp_q.size() == 0 && dlv_valid == 1'b0, "R9 single delivery", dlv_valid, 0);

      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) chk(1'b0, "watchdog", cyc, 20000);
      tick(2);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule